// File: doc/BRIEF.md
# Configuration Download Controller

This block keeps the working configuration of a chip in step with a paged nonvolatile store. The store holds 512 bytes in 16 pages of 32 bytes, mapped from bus address 0xF800 upward. The first seven pages hold configuration data. After each reset, and again whenever software asks for it, the block copies those 224 bytes into a working RAM that is seen at bus addresses 0x0000 to 0x00DF. The eighth page is reserved and the last eight pages are free for user data. Neither of these is ever copied.

A single byte-wide bus port reaches the store, the RAM and a control register at 0x00D8. A nonvolatile byte only accepts a write while it is blank, so software must clear a whole page before it rewrites data there. While a copy is running, `dl_active` is high so that the bus front end can hold off its traffic. The block also refuses writes and page clears during that time.

Top module: `cfgdl_ctrl`

## Requirements
- R1: Reset leaves every nonvolatile byte at 0xFF. `dl_active` is high during reset and for exactly 224 rising edges after reset is released, while bytes 0..223 are copied, and then it falls.
- R2: A copy writes the nonvolatile byte at 0xF800+n to RAM address n for every n from 0 to 223.
- R3: Bytes at 0xF8E0..0xF9FF (pages 7 to 15) are never copied. Bus addresses 0x00E0..0x00FF and any address outside the three mapped regions read 0x00.
- R4: A write to 0x00D8 with bit 0 set starts a copy when no copy is running. Reading 0x00D8 returns `dl_active` in bit 0, with zeros in bits 7:1. The bit returns to 0 by itself when the copy ends, 224 edges after the starting write.
- R5: A start request made while a copy is running has no effect, even in the last copy cycle. The copy still ends 224 edges after its own start and no new copy follows.
- R6: A bus write to a nonvolatile byte takes effect only when that byte holds 0xFF. Otherwise the byte keeps its value.
- R7: Pulsing `erase_en` with a page number sets all 32 bytes of that page to 0xFF and leaves every other page unchanged. If a clear and a write arrive in the same cycle, the clear wins.
- R8: While `dl_active` is high, bus writes to the RAM and to the nonvolatile store are ignored, and so are page clears.
- R9: `rd_data` shows, one rising edge after `addr` is presented, the byte addressed: the nonvolatile store for 0xF800..0xF9FF, the RAM for 0x0000..0x00DF except 0x00D8, or the control register for 0x00D8. While idle, a bus write to a RAM address is visible on the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for `addr`/`wr_data` |
| addr | input | 16 | Bus address for reads and writes |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Registered read data for the previous cycle's `addr` |
| erase_en | input | 1 | Page clear strobe |
| erase_page | input | 4 | Page to clear |
| dl_active | output | 1 | High while a copy is running |

## Verification
A bus write can arrive in the same cycle that the copy engine writes its final byte and drops `dl_active`. That write can be a start request, or it can be a RAM write that would compete with the engine for the RAM write port. The bench times both cases against its own edge counter so that they land exactly on the 224th copy edge. It then judges the result at the ports. `dl_active` must be low on that edge and on the next one, the control register must read 0, and the contested RAM byte must hold the copied nonvolatile value rather than the bus value. Earlier and mid-copy versions of the same conflicts are checked in the same way, alongside randomised write, clear and read traffic.

// File: rtl/cfgdl_pkg.sv
package cfgdl_pkg;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NV,
        SRC_RAM,
        SRC_CTRL
    } rd_src_e;
endpackage

// File: rtl/cfgdl_nv_array.sv
module cfgdl_nv_array
    import cfgdl_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int NUM_PAGES  = 16,
    localparam int NV_BYTES  = PAGE_BYTES * NUM_PAGES,
    localparam int IDX_W     = $clog2(NV_BYTES),
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             er_en,
    input  logic [PG_W-1:0]  er_page,
    input  logic [IDX_W-1:0] cp_idx,
    output logic [7:0]       cp_data,
    input  logic [IDX_W-1:0] bus_idx,
    output logic [7:0]       bus_data
);
    logic [7:0] mem_q [NV_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NV_BYTES; i++) mem_q[i] <= BLANK_BYTE;
        end else if (er_en) begin
            for (int j = 0; j < PAGE_BYTES; j++) mem_q[{er_page, OFF_W'(j)}] <= BLANK_BYTE;
        end else if (wr_en && mem_q[wr_idx] == BLANK_BYTE) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign cp_data  = mem_q[cp_idx];
    assign bus_data = mem_q[bus_idx];

    // R6
    blank_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !er_en && mem_q[wr_idx] != BLANK_BYTE)
        |=> mem_q[$past(wr_idx)] == $past(mem_q[wr_idx]));

    // R7
    page_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        er_en |=> (mem_q[{$past(er_page), OFF_W'(0)}] == BLANK_BYTE) &&
                  (mem_q[{$past(er_page), {OFF_W{1'b1}}}] == BLANK_BYTE));
endmodule

// File: rtl/cfgdl_ram.sv
module cfgdl_ram #(
    parameter int DEPTH = 224,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ridx,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[widx] <= wdata;
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/cfgdl_seq.sv
module cfgdl_seq #(
    parameter int CFG_BYTES = 224,
    localparam int AW       = $clog2(CFG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    output logic          busy,
    output logic [AW-1:0] cp_idx
);
    localparam logic [AW-1:0] LAST = AW'(CFG_BYTES - 1);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + AW'(1);
            end
        end else if (start_req) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b1;
            st_q.idx  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign cp_idx = st_q.idx;

    // R1
    end_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.idx) == LAST);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.idx != LAST)
        |=> st_q.busy && st_q.idx == $past(st_q.idx) + AW'(1));

    // R4
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && start_req) |=> st_q.busy && st_q.idx == '0);
endmodule

// File: rtl/cfgdl_ctrl.sv
module cfgdl_ctrl
    import cfgdl_pkg::*;
#(
    parameter int          PAGE_BYTES = 32,
    parameter int          NUM_PAGES  = 16,
    parameter int          CFG_PAGES  = 7,
    parameter logic [15:0] NV_BASE    = 16'hF800,
    parameter logic [15:0] CTRL_ADDR  = 16'h00D8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [15:0]                  addr,
    input  logic [7:0]                   wr_data,
    output logic [7:0]                   rd_data,
    input  logic                         erase_en,
    input  logic [$clog2(NUM_PAGES)-1:0] erase_page,
    output logic                         dl_active
);
    localparam int NV_BYTES  = PAGE_BYTES * NUM_PAGES;
    localparam int IDX_W     = $clog2(NV_BYTES);
    localparam int CFG_BYTES = CFG_PAGES * PAGE_BYTES;
    localparam int RAM_AW    = $clog2(CFG_BYTES);

    typedef struct packed {
        logic [7:0] rd_data;
    } top_t;

    top_t st_d, st_q;

    logic              busy;
    logic [RAM_AW-1:0] cp_idx;
    logic [7:0]        cp_data;
    logic [7:0]        nv_bus_data;
    logic [7:0]        ram_rdata;
    logic              nv_hit, ctrl_hit, ram_hit, in_cfg;
    logic [RAM_AW-1:0] ram_ridx;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_widx;
    logic [7:0]        ram_wdata;
    rd_src_e           src;

    generate
        if (CFG_BYTES == (1 << RAM_AW)) begin : g_full_ram
            assign in_cfg = 1'b1;
        end else begin : g_part_ram
            assign in_cfg = addr[RAM_AW-1:0] < RAM_AW'(CFG_BYTES);
        end
    endgenerate

    assign nv_hit   = addr[15:IDX_W] == NV_BASE[15:IDX_W];
    assign ctrl_hit = addr == CTRL_ADDR;
    assign ram_hit  = (addr[15:RAM_AW] == '0) && in_cfg && !ctrl_hit;
    assign ram_ridx = ram_hit ? addr[RAM_AW-1:0] : '0;

    assign ram_we    = busy | (wr_en & ram_hit);
    assign ram_widx  = busy ? cp_idx : addr[RAM_AW-1:0];
    assign ram_wdata = busy ? cp_data : wr_data;

    cfgdl_seq #(.CFG_BYTES(CFG_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (wr_en & ctrl_hit & wr_data[0]),
        .busy      (busy),
        .cp_idx    (cp_idx)
    );

    cfgdl_nv_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_nv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en & nv_hit & ~busy),
        .wr_idx   (addr[IDX_W-1:0]),
        .wr_data  (wr_data),
        .er_en    (erase_en & ~busy),
        .er_page  (erase_page),
        .cp_idx   (IDX_W'(cp_idx)),
        .cp_data  (cp_data),
        .bus_idx  (addr[IDX_W-1:0]),
        .bus_data (nv_bus_data)
    );

    cfgdl_ram #(.DEPTH(CFG_BYTES)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .widx  (ram_widx),
        .wdata (ram_wdata),
        .ridx  (ram_ridx),
        .rdata (ram_rdata)
    );

    always_comb begin
        if (nv_hit)        src = SRC_NV;
        else if (ctrl_hit) src = SRC_CTRL;
        else if (ram_hit)  src = SRC_RAM;
        else               src = SRC_NONE;

        st_d = st_q;
        case (src)
            SRC_NV:   st_d.rd_data = nv_bus_data;
            SRC_RAM:  st_d.rd_data = ram_rdata;
            SRC_CTRL: st_d.rd_data = {7'b0, busy};
            default:  st_d.rd_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rd_data;
    assign dl_active = busy;

    // R4
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> rd_data == {7'b0, $past(busy)});

    // R3
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:8] == 8'h00 && addr[7:0] >= 8'(CFG_BYTES)) |=> rd_data == 8'h00);
endmodule

// File: tb/cfgdl_ctrl_bench.sv
module cfgdl_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        erase_en = 1'b0;
    logic [3:0]  erase_page = 4'h0;
    logic        dl_active;

    int n_checks = 0;
    int n_err    = 0;
    int unsigned tick = 0;
    int unsigned start = 0;
    logic [7:0] nv_m [512];
    logic [7:0] ram_m [224];

    always #4 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    cfgdl_ctrl u_cfgdl_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .erase_en(erase_en), .erase_page(erase_page),
        .dl_active(dl_active)
    );

    function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic bsy);
        if (a[15:9] == 7'h7C) return nv_m[a[8:0]];
        if (a == 16'h00D8) return {7'b0, bsy};
        if (a[15:8] == 8'h00 && a[7:0] < 8'd224) return ram_m[a[7:0]];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd_check(input logic [15:0] a, input logic bsy, input string req);
        addr  = a;
        wr_en = 1'b0;
        @(negedge clk);
        check(req, rd_data, exp_rd(a, bsy));
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic nv_write(input int off, input logic [7:0] d, input bit live);
        bus_wr(16'hF800 + 16'(off), d);
        if (live && nv_m[off] == 8'hFF) nv_m[off] = d;
    endtask

    task automatic ram_write(input int a, input logic [7:0] d, input bit live);
        bus_wr(16'(a), d);
        if (live) ram_m[a] = d;
    endtask

    task automatic erase(input int p, input bit live);
        erase_page = 4'(p); erase_en = 1'b1;
        @(negedge clk);
        erase_en = 1'b0;
        if (live) for (int j = 0; j < 32; j++) nv_m[p*32 + j] = 8'hFF;
    endtask

    task automatic wait_to(input int unsigned n);
        while ((tick - start) < n) @(negedge clk);
    endtask

    task automatic full_compare();
        for (int n = 0; n < 224; n++)
            if (n != 8'hD8) rd_check(16'(n), 1'b0, "R2");
        for (int n = 0; n < 512; n++) rd_check(16'hF800 + 16'(n), 1'b0, "R7");
        rd_check(16'h00D8, 1'b0, "R4");
        rd_check(16'h00E0, 1'b0, "R3");
        rd_check(16'h00FF, 1'b0, "R3");
    endtask

    task automatic run_download(input int variant);
        bus_wr(16'h00D8, 8'h01);
        start = tick;
        rd_check(16'h00D8, 1'b1, "R4");
        case (variant)
            0: begin wait_to(100); bus_wr(16'h00D8, 8'h01); end
            1: begin
                wait_to(50);
                nv_write(16'h60, 8'h00, 1'b0);
                erase(4, 1'b0);
                ram_write(16'h30, 8'h5A, 1'b0);
            end
            2: begin
                wait_to(223);
                check("R5", {7'b0, dl_active}, 8'h01);
                bus_wr(16'h00D8, 8'h01);
            end
            3: begin
                wait_to(223);
                check("R8", {7'b0, dl_active}, 8'h01);
                ram_write(5, ~nv_m[5], 1'b0);
            end
            default: ;
        endcase
        if ((tick - start) < 224) begin
            wait_to(223);
            check("R4", {7'b0, dl_active}, 8'h01);
        end
        wait_to(224);
        check("R5", {7'b0, dl_active}, 8'h00);
        @(negedge clk);
        check("R5", {7'b0, dl_active}, 8'h00);
        for (int n = 0; n < 224; n++) ram_m[n] = nv_m[n];
    endtask

    task automatic random_ops(input int count);
        for (int k = 0; k < count; k++) begin
            int unsigned r;
            r = $urandom % 8;
            case (r)
                0: erase(int'($urandom % 16), 1'b1);
                1, 2, 3, 4: nv_write(int'($urandom % 512),
                                     ($urandom % 3 == 0) ? 8'hFF : 8'($urandom), 1'b1);
                5, 6: begin
                    int a;
                    a = int'($urandom % 224);
                    if (a == 'hD8) a = 'hD7;
                    ram_write(a, 8'($urandom), 1'b1);
                end
                default: begin
                    if ($urandom % 2 == 0) rd_check(16'hF800 + 16'($urandom % 512), 1'b0, "R9");
                    else rd_check(16'($urandom % 216), 1'b0, "R9");
                end
            endcase
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int n = 0; n < 512; n++) nv_m[n] = 8'hFF;
        for (int n = 0; n < 224; n++) ram_m[n] = 8'hFF;
        repeat (5) @(negedge clk);
        check("R1", {7'b0, dl_active}, 8'h01);
        rst_n = 1'b1;
        start = tick;
        wait_to(223);
        check("R1", {7'b0, dl_active}, 8'h01);
        wait_to(224);
        check("R1", {7'b0, dl_active}, 8'h00);
        rd_check(16'h00D8, 1'b0, "R4");
        rd_check(16'h0000, 1'b0, "R1");
        rd_check(16'h00DF, 1'b0, "R1");
        rd_check(16'hF9FF, 1'b0, "R1");

        // R6 / R7 directed: blank rule and page clear
        nv_write(5, 8'h12, 1'b1);
        rd_check(16'hF805, 1'b0, "R6");
        nv_write(5, 8'h34, 1'b1);
        rd_check(16'hF805, 1'b0, "R6");
        nv_write(32, 8'h56, 1'b1);
        erase(0, 1'b1);
        rd_check(16'hF805, 1'b0, "R7");
        rd_check(16'hF820, 1'b0, "R7");
        nv_write(5, 8'h34, 1'b1);
        rd_check(16'hF805, 1'b0, "R6");

        // R9 / R3 directed
        ram_write(16'h10, 8'hA5, 1'b1);
        rd_check(16'h0010, 1'b0, "R9");
        rd_check(16'h00E0, 1'b0, "R3");
        rd_check(16'h1234, 1'b0, "R3");
        nv_write(16'hE0, 8'h77, 1'b1);
        nv_write(16'h1FF, 8'h66, 1'b1);

        for (int round = 0; round < 4; round++) begin
            random_ops(40);
            if (round == 1) begin
                erase(3, 1'b1);
                erase(4, 1'b1);
                nv_write(16'h80, 8'h11, 1'b1);
            end
            run_download(round);
            full_compare();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule